// File: doc/BRIEF.md
# Starvation Request Arbitration Table

This block keeps track of cache lines on which one or more requesters have fallen back to a starvation-avoidance ("persistent") request in a token-based coherence scheme. For each tracked line it holds the line address and three sets of requesters, one bit per requester. The first set holds the requesters currently starving on the line. The second is a snapshot of the starving set, taken by a mark command. The third holds the starving requesters that want write access.

A controller sends one command per cycle. A lock command adds a requester to a line. An unlock command removes a requester from a line. A mark command takes the snapshot. A separate query port reads the current state without a clock. For the queried address it reports whether the asking requester may issue a new starvation request, which requester has priority and whether that requester wants to write, and two counts: starving requesters and read-only starving requesters. Requesters are numbered flat from 0 to N_REQ-1, and a lower number always wins. Lines are matched fully associatively across a parameterized number of table slots.

Top module: `prt_table`

## Requirements
- R1: Command codes on `cmd_op` are 0 idle, 1 lock, 2 unlock and 3 mark, and each takes effect at the next rising clock edge. A lock for an address with no slot allocates a free slot holding only that requester. A lock for a tracked address adds the requester to its starving set.
- R2: A lock with `cmd_write`=1 also records the requester as a writer. A lock with `cmd_write`=0 leaves the writer set unchanged.
- R3: `err_o` is high in the cycle after an erroneous command and leaves the table unchanged. Erroneous commands are: a lock from a requester already starving on that address, an unlock from a requester not starving on it, and an unlock for an untracked address.
- R4: A valid unlock removes the requester from the starving, snapshot and writer sets of that line.
- R5: When an unlock empties the starving set, the slot is released, and the address then reads as untracked.
- R6: `q_may_issue` is 1 for an untracked address. It is 0 when `q_req` is already starving on the address. Otherwise it is 1 only when the snapshot set is empty.
- R7: `q_prio_req` is the lowest-numbered starving requester on `q_addr`. `q_prio_valid` is 0 when the address is untracked.
- R8: `q_prio_write` is 1 when the priority requester is in the writer set, and 0 otherwise.
- R9: A mark on a tracked address copies the starving set into the snapshot set. A mark is an error (R3 timing) when the snapshot set is not empty. A mark on an untracked address changes nothing and raises no error.
- R10: `q_starve_cnt` is the size of the starving set, and `q_read_cnt` is that size minus the size of the writer set. Both counts are 0 for an untracked address.
- R11: `full_o` is 1 while every slot is in use. A lock that needs a new slot while the table is full is dropped without an error.
- R12: The snapshot set stays a subset of the starving set. Once every snapshotted requester has unlocked, new requests are allowed again even if other requesters are still starving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 idle, 1 lock, 2 unlock, 3 mark |
| cmd_addr | input | ADDR_W | Line address of the command |
| cmd_req | input | $clog2(N_REQ) | Requester issuing the command |
| cmd_write | input | 1 | Lock wants write access |
| q_addr | input | ADDR_W | Line address being queried |
| q_req | input | $clog2(N_REQ) | Requester asking whether it may issue |
| err_o | output | 1 | Previous command was erroneous |
| full_o | output | 1 | All slots in use |
| q_may_issue | output | 1 | Asking requester may start a starvation request |
| q_prio_valid | output | 1 | Queried address is tracked |
| q_prio_req | output | $clog2(N_REQ) | Lowest-numbered starving requester |
| q_prio_write | output | 1 | Priority requester wants write |
| q_starve_cnt | output | $clog2(N_REQ+1) | Number of starving requesters |
| q_read_cnt | output | $clog2(N_REQ+1) | Starving requesters without write intent |

## Verification
The hardest condition to reach is the gate that the snapshot places on new requests. Reaching it takes a mark, then a late lock from a requester outside the snapshot, then unlocks of the snapshotted requesters in turn. Only at the end of that sequence may `q_may_issue` return to 1 while the line still has starving requesters. The stimulus builds exactly that sequence on one address and probes the gate after each step. It then re-marks the line to show that a second snapshot is accepted only once the first has drained. Full-table drops are reached by filling every slot with distinct addresses before the extra lock.

// File: rtl/prt_pkg.sv
package prt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_MARK   = 2'd3
    } prt_op_e;

    // Decision taken for the command of the current cycle
    typedef struct packed {
        logic wr_en;   // a slot is written
        logic alloc;   // slot is newly allocated
        logic release_slot; // slot is freed
        logic err;     // command is erroneous
    } prt_act_t;

endpackage

// File: rtl/prt_first.sv
module prt_first #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prt_lookup.sv
module prt_lookup #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]        key,
    output logic                     hit,
    output logic [IW-1:0]            idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (addrs[g] == key);
    end

    prt_first #(.W(N), .IW(IW)) u_enc (
        .vec (match),
        .any (hit),
        .idx (idx)
    );
endmodule

// File: rtl/prt_prio.sv
module prt_prio #(
    parameter int N_REQ  = 16,
    localparam int RW    = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int CW    = $clog2(N_REQ + 1)
) (
    input  logic [N_REQ-1:0] starving,
    input  logic [N_REQ-1:0] writers,
    output logic             any,
    output logic [RW-1:0]    winner,
    output logic             winner_wr,
    output logic [CW-1:0]    cnt_all,
    output logic [CW-1:0]    cnt_read
);
    logic [CW-1:0] cnt_wr;

    prt_first #(.W(N_REQ), .IW(RW)) u_pick (
        .vec (starving),
        .any (any),
        .idx (winner)
    );

    assign winner_wr = any && writers[winner];

    always_comb begin
        cnt_all = '0;
        cnt_wr  = '0;
        for (int i = 0; i < N_REQ; i++) begin
            cnt_all = cnt_all + CW'(starving[i]);
            cnt_wr  = cnt_wr  + CW'(writers[i]);
        end
        cnt_read = cnt_all - cnt_wr;
    end
endmodule

// File: rtl/prt_table.sv
module prt_table
    import prt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_ENTRIES = 8,
    parameter int N_REQ     = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int RW       = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int CW       = $clog2(N_REQ + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [RW-1:0]     cmd_req,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [RW-1:0]     q_req,
    output logic              err_o,
    output logic              full_o,
    output logic              q_may_issue,
    output logic              q_prio_valid,
    output logic [RW-1:0]     q_prio_req,
    output logic              q_prio_write,
    output logic [CW-1:0]     q_starve_cnt,
    output logic [CW-1:0]     q_read_cnt
);
    // ---------------- table state ----------------
    logic [N_ENTRIES-1:0]             slot_vld;
    logic [N_ENTRIES-1:0][ADDR_W-1:0] slot_addr;
    logic [N_ENTRIES-1:0][N_REQ-1:0]  slot_stv;
    logic [N_ENTRIES-1:0][N_REQ-1:0]  slot_mrk;
    logic [N_ENTRIES-1:0][N_REQ-1:0]  slot_wrs;

    prt_op_e op;
    assign op = prt_op_e'(cmd_op);

    // ---------------- command path ----------------
    logic          c_hit;
    logic [IW-1:0] c_idx;
    logic          f_any;
    logic [IW-1:0] f_idx;

    prt_lookup #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_cmd_lu (
        .valid (slot_vld),
        .addrs (slot_addr),
        .key   (cmd_addr),
        .hit   (c_hit),
        .idx   (c_idx)
    );

    prt_first #(.W(N_ENTRIES), .IW(IW)) u_free (
        .vec (~slot_vld),
        .any (f_any),
        .idx (f_idx)
    );

    assign full_o = ~f_any;

    logic [N_REQ-1:0] req_bit;
    logic [N_REQ-1:0] cur_stv, cur_mrk, cur_wrs;
    logic [N_REQ-1:0] nxt_stv, nxt_mrk, nxt_wrs;
    logic [IW-1:0]    w_idx;
    prt_act_t         act;

    assign req_bit = N_REQ'(1) << cmd_req;
    assign cur_stv = slot_stv[c_idx];
    assign cur_mrk = slot_mrk[c_idx];
    assign cur_wrs = slot_wrs[c_idx];

    always_comb begin
        act     = '0;
        w_idx   = c_idx;
        nxt_stv = cur_stv;
        nxt_mrk = cur_mrk;
        nxt_wrs = cur_wrs;
        unique case (op)
            OP_LOCK: begin
                if (c_hit) begin
                    if ((cur_stv & req_bit) != '0) begin
                        act.err = 1'b1;
                    end else begin
                        act.wr_en = 1'b1;
                        nxt_stv   = cur_stv | req_bit;
                        nxt_wrs   = cmd_write ? (cur_wrs | req_bit) : cur_wrs;
                    end
                end else if (f_any) begin
                    act.wr_en = 1'b1;
                    act.alloc = 1'b1;
                    w_idx     = f_idx;
                    nxt_stv   = req_bit;
                    nxt_mrk   = '0;
                    nxt_wrs   = cmd_write ? req_bit : '0;
                end
                // full and missing: lock is dropped
            end
            OP_UNLOCK: begin
                if (!c_hit || ((cur_stv & req_bit) == '0)) begin
                    act.err = 1'b1;
                end else begin
                    act.wr_en = 1'b1;
                    nxt_stv   = cur_stv & ~req_bit;
                    nxt_mrk   = cur_mrk & ~req_bit;
                    nxt_wrs   = cur_wrs & ~req_bit;
                    act.release_slot = (nxt_stv == '0);
                end
            end
            OP_MARK: begin
                if (c_hit) begin
                    if (cur_mrk != '0) begin
                        act.err = 1'b1;
                    end else begin
                        act.wr_en = 1'b1;
                        nxt_mrk   = cur_stv;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld  <= '0;
            slot_addr <= '0;
            slot_stv  <= '0;
            slot_mrk  <= '0;
            slot_wrs  <= '0;
            err_o     <= 1'b0;
        end else begin
            err_o <= act.err;
            if (act.wr_en) begin
                slot_stv[w_idx] <= nxt_stv;
                slot_mrk[w_idx] <= nxt_mrk;
                slot_wrs[w_idx] <= nxt_wrs;
                if (act.alloc) begin
                    slot_vld[w_idx]  <= 1'b1;
                    slot_addr[w_idx] <= cmd_addr;
                end
                if (act.release_slot) begin
                    slot_vld[w_idx] <= 1'b0;
                end
            end
        end
    end

    // ---------------- query path ----------------
    logic             q_hit;
    logic [IW-1:0]    q_idx;
    logic [N_REQ-1:0] q_stv, q_mrk, q_wrs;

    prt_lookup #(.N(N_ENTRIES), .ADDR_W(ADDR_W)) u_q_lu (
        .valid (slot_vld),
        .addrs (slot_addr),
        .key   (q_addr),
        .hit   (q_hit),
        .idx   (q_idx)
    );

    assign q_stv = q_hit ? slot_stv[q_idx] : '0;
    assign q_mrk = q_hit ? slot_mrk[q_idx] : '0;
    assign q_wrs = q_hit ? slot_wrs[q_idx] : '0;

    prt_prio #(.N_REQ(N_REQ)) u_prio (
        .starving  (q_stv),
        .writers   (q_wrs),
        .any       (q_prio_valid),
        .winner    (q_prio_req),
        .winner_wr (q_prio_write),
        .cnt_all   (q_starve_cnt),
        .cnt_read  (q_read_cnt)
    );

    always_comb begin
        if (!q_hit)              q_may_issue = 1'b1;
        else if (q_stv[q_req])   q_may_issue = 1'b0;
        else                     q_may_issue = (q_mrk == '0);
    end

    // ---------------- assertions ----------------
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
        // R12: snapshot never holds a requester that is not starving
        a_r12_marked_subset: assert property (@(posedge clk) disable iff (rst)
            slot_vld[g] |-> ((slot_mrk[g] & ~slot_stv[g]) == '0));
        // R2: writer set stays inside the starving set
        a_r2_writer_subset: assert property (@(posedge clk) disable iff (rst)
            slot_vld[g] |-> ((slot_wrs[g] & ~slot_stv[g]) == '0));
        // R5: a live slot never has an empty starving set
        a_r5_live_nonempty: assert property (@(posedge clk) disable iff (rst)
            slot_vld[g] |-> (slot_stv[g] != '0));
    end

    // R3: an erroneous command leaves the table untouched
    a_r3_err_no_change: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(slot_vld) && $stable(slot_stv) && $stable(slot_mrk)
                   && $stable(slot_wrs)));

    // R11: a lock needing a new slot in a full table is dropped
    a_r11_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full_o && op == OP_LOCK && !c_hit) |=> ($stable(slot_vld) && !err_o));

    // R7: the priority requester is a member of the queried starving set
    a_r7_prio_member: assert property (@(posedge clk) disable iff (rst)
        q_prio_valid |-> q_stv[q_prio_req]);

    // R10: read-only count never exceeds the total count
    a_r10_count_order: assert property (@(posedge clk) disable iff (rst)
        q_read_cnt <= q_starve_cnt);

endmodule

// File: tb/prt_table_test.sv
module prt_table_test;
    localparam int ADDR_W = 32;
    localparam int N_ENT  = 8;
    localparam int N_REQ  = 16;
    localparam int RW     = $clog2(N_REQ);
    localparam int CW     = $clog2(N_REQ + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [RW-1:0]     cmd_req;
    logic              cmd_write;
    logic [ADDR_W-1:0] q_addr;
    logic [RW-1:0]     q_req;
    logic              err_o, full_o, q_may_issue, q_prio_valid, q_prio_write;
    logic [RW-1:0]     q_prio_req;
    logic [CW-1:0]     q_starve_cnt, q_read_cnt;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    prt_table #(.ADDR_W(ADDR_W), .N_ENTRIES(N_ENT), .N_REQ(N_REQ)) uut (
        .clk, .rst, .cmd_op, .cmd_addr, .cmd_req, .cmd_write,
        .q_addr, .q_req, .err_o, .full_o, .q_may_issue, .q_prio_valid,
        .q_prio_req, .q_prio_write, .q_starve_cnt, .q_read_cnt
    );

    localparam logic [1:0] IDLE = 2'd0, LOCK = 2'd1, UNLK = 2'd2, MARK = 2'd3;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // apply one command; returns at the falling edge after it took effect
    task automatic do_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input int r, input logic w);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_req = RW'(r); cmd_write = w;
        @(negedge clk);
        cmd_op = IDLE;
    endtask

    task automatic ask(input logic [ADDR_W-1:0] a, input int r);
        q_addr = a; q_req = RW'(r);
        #1;
    endtask

    task automatic t_reset;
        ask(32'h100, 0);
        chk("R11 full after reset", int'(full_o), 0);
        chk("R3 err after reset", int'(err_o), 0);
        chk("R6 may untracked", int'(q_may_issue), 1);
        chk("R7 prio_valid untracked", int'(q_prio_valid), 0);
        chk("R10 count untracked", int'(q_starve_cnt), 0);
        chk("R10 read count untracked", int'(q_read_cnt), 0);
    endtask

    task automatic t_lock_unlock;
        do_cmd(LOCK, 32'h100, 5, 1'b0);
        do_cmd(LOCK, 32'h100, 3, 1'b1);
        do_cmd(LOCK, 32'h100, 9, 1'b1);
        ask(32'h100, 0);
        chk("R1 count after three locks", int'(q_starve_cnt), 3);
        chk("R10 read count", int'(q_read_cnt), 1);
        chk("R7 prio lowest", int'(q_prio_req), 3);
        chk("R8 prio write", int'(q_prio_write), 1);
        chk("R6 may with empty snapshot", int'(q_may_issue), 1);
        chk("R3 no err on good locks", int'(err_o), 0);
        ask(32'h100, 5);
        chk("R6 may starving requester", int'(q_may_issue), 0);
        do_cmd(UNLK, 32'h100, 3, 1'b0);
        ask(32'h100, 0);
        chk("R4 count after unlock", int'(q_starve_cnt), 2);
        chk("R4 read count after unlock", int'(q_read_cnt), 1);
        chk("R7 prio next", int'(q_prio_req), 5);
        chk("R2 read lock prio type", int'(q_prio_write), 0);
        do_cmd(UNLK, 32'h100, 5, 1'b0);
        ask(32'h100, 0);
        chk("R7 prio last", int'(q_prio_req), 9);
        chk("R8 prio write last", int'(q_prio_write), 1);
        do_cmd(UNLK, 32'h100, 9, 1'b0);
        ask(32'h100, 0);
        chk("R5 freed count", int'(q_starve_cnt), 0);
        chk("R5 freed prio_valid", int'(q_prio_valid), 0);
        chk("R5 freed may", int'(q_may_issue), 1);
        // re-lock with read: write intent of requester 3 must be gone
        do_cmd(LOCK, 32'h100, 3, 1'b0);
        ask(32'h100, 0);
        chk("R4 writer cleared", int'(q_prio_write), 0);
        chk("R2 read count", int'(q_read_cnt), 1);
        do_cmd(UNLK, 32'h100, 3, 1'b0);
    endtask

    task automatic t_errors;
        do_cmd(LOCK, 32'h200, 2, 1'b0);
        do_cmd(LOCK, 32'h200, 2, 1'b1);
        ask(32'h200, 0);
        chk("R3 double lock err", int'(err_o), 1);
        chk("R3 double lock no change", int'(q_starve_cnt), 1);
        chk("R3 double lock writer unchanged", int'(q_prio_write), 0);
        @(negedge clk);
        chk("R3 err clears", int'(err_o), 0);
        do_cmd(UNLK, 32'h200, 7, 1'b0);
        ask(32'h200, 0);
        chk("R3 unlock non-member err", int'(err_o), 1);
        chk("R3 unlock non-member no change", int'(q_starve_cnt), 1);
        do_cmd(UNLK, 32'h300, 1, 1'b0);
        ask(32'h300, 0);
        chk("R3 unlock missing err", int'(err_o), 1);
        chk("R3 unlock missing no alloc", int'(q_starve_cnt), 0);
        do_cmd(MARK, 32'h300, 0, 1'b0);
        ask(32'h300, 0);
        chk("R9 mark missing no err", int'(err_o), 0);
        chk("R9 mark missing no alloc", int'(q_prio_valid), 0);
        do_cmd(UNLK, 32'h200, 2, 1'b0);
        ask(32'h200, 0);
        chk("R4 good unlock no err", int'(err_o), 0);
        chk("R5 freed", int'(q_starve_cnt), 0);
    endtask

    task automatic t_mark;
        do_cmd(LOCK, 32'h400, 4, 1'b0);
        do_cmd(LOCK, 32'h400, 6, 1'b1);
        do_cmd(MARK, 32'h400, 0, 1'b0);
        ask(32'h400, 1);
        chk("R9 mark ok", int'(err_o), 0);
        chk("R6 blocked by snapshot", int'(q_may_issue), 0);
        do_cmd(MARK, 32'h400, 0, 1'b0);
        chk("R9 second mark err", int'(err_o), 1);
        do_cmd(LOCK, 32'h400, 1, 1'b0);
        ask(32'h400, 2);
        chk("R1 late lock accepted", int'(q_starve_cnt), 3);
        chk("R7 late lock prio", int'(q_prio_req), 1);
        chk("R6 still blocked", int'(q_may_issue), 0);
        do_cmd(UNLK, 32'h400, 4, 1'b0);
        ask(32'h400, 2);
        chk("R12 one marked left", int'(q_may_issue), 0);
        do_cmd(UNLK, 32'h400, 6, 1'b0);
        ask(32'h400, 2);
        chk("R12 snapshot drained", int'(q_may_issue), 1);
        chk("R12 other still starving", int'(q_starve_cnt), 1);
        do_cmd(MARK, 32'h400, 0, 1'b0);
        ask(32'h400, 2);
        chk("R9 re-mark after drain ok", int'(err_o), 0);
        chk("R9 re-mark blocks", int'(q_may_issue), 0);
        do_cmd(UNLK, 32'h400, 1, 1'b0);
        ask(32'h400, 2);
        chk("R5 freed after mark", int'(q_may_issue), 1);
    endtask

    task automatic t_full;
        for (int i = 0; i < N_ENT; i++) begin
            do_cmd(LOCK, 32'h1000 + 32'(i) * 32'h40, 0, 1'b0);
        end
        ask(32'h2000, 0);
        chk("R11 full set", int'(full_o), 1);
        do_cmd(LOCK, 32'h2000, 0, 1'b1);
        ask(32'h2000, 0);
        chk("R11 drop no err", int'(err_o), 0);
        chk("R11 dropped", int'(q_starve_cnt), 0);
        chk("R11 still full", int'(full_o), 1);
        ask(32'h1000 + 32'h40 * 7, 0);
        chk("R1 last slot tracked", int'(q_starve_cnt), 1);
        do_cmd(UNLK, 32'h1000, 0, 1'b0);
        chk("R11 full clears", int'(full_o), 0);
        do_cmd(LOCK, 32'h2000, 0, 1'b1);
        ask(32'h2000, 0);
        chk("R1 alloc in freed slot", int'(q_starve_cnt), 1);
        chk("R2 write alloc", int'(q_prio_write), 1);
        chk("R11 full again", int'(full_o), 1);
    endtask

    initial begin
        rst = 1'b1; cmd_op = IDLE; cmd_addr = '0; cmd_req = '0; cmd_write = 1'b0;
        q_addr = '0; q_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock_unlock();
        t_errors();
        t_mark();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule